// File: doc/BRIEF.md
# UART Receive Queue Controller

This block stores bytes coming out of a UART receiver into a RAM buffer without help from the processor. Software programs a buffer start address, a byte count, an optional terminating character and a control word. From then on each received byte is written at the current address; the address then steps up by one and the count steps down by one.

Three end-of-buffer policies are available. In the linear policy the queue stops when the count reaches zero. In the continue policy it keeps writing past the end. In the circular policy the address and count go back to their programmed values. Independently, a match on the terminating character stops the queue. A software halt bit and an active-low external halt pin freeze transfers. While the queue is frozen, one received byte is held in a single-entry holding register. A receive flag tells software that a buffer boundary or a terminator was seen.

Top module: `uart_rxq`

## Requirements
- R1: After synchronous reset, the current address, current count, match character, control word, receive flag and overrun flag are all zero, and `mem_we` is low.
- R2: When a byte is accepted on `rx_valid`, it is written to memory during the next cycle, provided the queue is enabled, running and not halted. In that cycle `mem_we` is high, `mem_addr` equals the current address and `mem_wdata` equals the byte. On the following edge the address increments by one and the count decrements by one.
- R3: With match enable set, a written byte equal to the match character sets the receive flag and clears the run bit. No later byte is written.
- R4: With neither continue nor circular set, the write that brings the count to zero sets the receive flag and clears the run bit. A later byte is not written.
- R5: With continue set and circular clear, the write that brings the count to zero sets the receive flag and leaves the run bit set. The next byte is written at the following address, and the count wraps to all ones.
- R6: With circular set, the write that brings the count to zero sets the receive flag. It reloads the address with the programmed start and the count with the programmed length, and leaves the run bit set.
- R7: While the control halt bit is set, no memory write occurs. The held byte is written in the cycle after the halt bit is written back to zero.
- R8: While `ext_halt_n` is low, no memory write occurs. The held byte is written in the first cycle that `ext_halt_n` is high.
- R9: When a byte arrives while an earlier byte is still held and not being written, the overrun flag is set and stays set. The earlier byte is kept and the later one is discarded.
- R10: A write to the clear selector (code 4) clears the receive flag where data bit 0 is one and the overrun flag where data bit 1 is one. Zero bits leave the flags unchanged.
- R11: A single write to the control selector (code 3) sets all six control bits together. The bits are: bit 0 queue enable, bit 1 match enable, bit 2 continue, bit 3 circular, bit 4 run, bit 5 halt. The new word is visible on `cur_ctrl` after that edge.
- R12: With queue enable clear, no memory write occurs even when run is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_valid | input | 1 | Received byte strobe |
| rx_byte | input | DW | Received byte |
| ext_halt_n | input | 1 | External halt, active low |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 3 | Register select: 0 length, 1 start address, 2 match, 3 control, 4 flag clear |
| cfg_wdata | input | AW | Register write data |
| mem_we | output | 1 | Buffer write enable |
| mem_addr | output | AW | Buffer write address |
| mem_wdata | output | DW | Buffer write data |
| cur_addr | output | AW | Current address register |
| cur_size | output | SW | Current count register |
| cur_ctrl | output | 6 | Current control word |
| rx_flag | output | 1 | Receive flag |
| ovr_flag | output | 1 | Overrun flag |

## Verification
The bench builds the block with an 8-bit address, an 8-bit data path and a 4-bit count. With the narrow count, the continue policy's wrap of the count to all ones shows up after only a few bytes. Buffers of two to six bytes cover the linear stop, the circular reload and the terminator match in short runs. Both halt paths, and the overrun of the single holding register, are driven with the bytes held back so that the order of writes can be seen on the memory port.

// File: rtl/uart_rxq_pkg.sv
package uart_rxq_pkg;

    localparam int CTRL_W = 6;

    typedef struct packed {
        logic halt;
        logic run;
        logic circ;
        logic cont;
        logic match_en;
        logic q_en;
    } rxq_ctrl_t;

    typedef enum logic [2:0] {
        SEL_SIZE  = 3'd0,
        SEL_ADDR  = 3'd1,
        SEL_MATCH = 3'd2,
        SEL_CTRL  = 3'd3,
        SEL_CLR   = 3'd4
    } rxq_sel_e;

    typedef struct packed {
        logic stop;
        logic flag;
        logic reload;
    } rxq_verdict_t;

    // Decide what a single write does to the queue state.
    function automatic rxq_verdict_t judge(rxq_ctrl_t c, logic hit, logic last);
        rxq_verdict_t v;
        logic term;
        term     = c.match_en & hit;
        v.stop   = term | (last & ~c.circ & ~c.cont);
        v.flag   = term | last;
        v.reload = last & c.circ & ~term;
        return v;
    endfunction

endpackage

// File: rtl/rxq_pend.sv
module rxq_pend #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          rx_valid,
    input  logic [DW-1:0] rx_byte,
    input  logic          take,
    output logic          pend_v,
    output logic [DW-1:0] pend_data,
    output logic          ovr_evt
);

    assign ovr_evt = rx_valid & pend_v & ~take;

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_v    <= 1'b0;
            pend_data <= '0;
        end else if (rx_valid && (!pend_v || take)) begin
            pend_v    <= 1'b1;
            pend_data <= rx_byte;
        end else if (take) begin
            pend_v    <= 1'b0;
        end
    end

    // R9: the held byte survives an overrun
    AST_PEND_KEPT: assert property (@(posedge clk) disable iff (rst)
        ovr_evt |=> (pend_v && pend_data == $past(pend_data))); // R9

endmodule

// File: rtl/rxq_engine.sv
module rxq_engine
    import uart_rxq_pkg::*;
#(
    parameter int AW = 16,
    parameter int SW = 8,
    parameter int DW = 8
) (
    input  rxq_ctrl_t     ctrl,
    input  logic          ext_halt_n,
    input  logic          pend_v,
    input  logic [DW-1:0] pend_data,
    input  logic [DW-1:0] match_chr,
    input  logic [AW-1:0] addr,
    input  logic [SW-1:0] size,
    output logic          xfer,
    output rxq_verdict_t  verdict,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_wdata
);

    localparam logic [SW-1:0] ONE = SW'(1);

    logic go;
    logic hit;
    logic last;

    always_comb begin
        go        = ctrl.q_en & ctrl.run & ~ctrl.halt & ext_halt_n;
        xfer      = pend_v & go;
        hit       = (pend_data == match_chr);
        last      = (size == ONE);
        verdict   = judge(ctrl, hit, last);
        mem_we    = xfer;
        mem_addr  = addr;
        mem_wdata = pend_data;
    end

endmodule

// File: rtl/rxq_regs.sv
module rxq_regs
    import uart_rxq_pkg::*;
#(
    parameter int AW = 16,
    parameter int SW = 8,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          cfg_we,
    input  logic [2:0]    cfg_sel,
    input  logic [AW-1:0] cfg_wdata,
    input  logic          xfer,
    input  rxq_verdict_t  verdict,
    input  logic          ovr_evt,
    output rxq_ctrl_t     ctrl,
    output logic [AW-1:0] addr,
    output logic [SW-1:0] size,
    output logic [AW-1:0] addr_start,
    output logic [SW-1:0] size_init,
    output logic [DW-1:0] match_chr,
    output logic          rx_flag,
    output logic          ovr_flag
);

    logic wr_size, wr_addr, wr_match, wr_ctrl, wr_clr;

    always_comb begin
        wr_size  = cfg_we && (cfg_sel == SEL_SIZE);
        wr_addr  = cfg_we && (cfg_sel == SEL_ADDR);
        wr_match = cfg_we && (cfg_sel == SEL_MATCH);
        wr_ctrl  = cfg_we && (cfg_sel == SEL_CTRL);
        wr_clr   = cfg_we && (cfg_sel == SEL_CLR);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            addr       <= '0;
            addr_start <= '0;
            size       <= '0;
            size_init  <= '0;
            match_chr  <= '0;
            ctrl       <= '0;
            rx_flag    <= 1'b0;
            ovr_flag   <= 1'b0;
        end else begin
            if (wr_addr) begin
                addr       <= cfg_wdata;
                addr_start <= cfg_wdata;
            end else if (xfer) begin
                addr <= verdict.reload ? addr_start : addr + 1'b1;
            end

            if (wr_size) begin
                size      <= cfg_wdata[SW-1:0];
                size_init <= cfg_wdata[SW-1:0];
            end else if (xfer) begin
                size <= verdict.reload ? size_init : size - 1'b1;
            end

            if (wr_match)
                match_chr <= cfg_wdata[DW-1:0];

            if (wr_ctrl)
                ctrl <= rxq_ctrl_t'(cfg_wdata[CTRL_W-1:0]);
            else if (xfer && verdict.stop)
                ctrl.run <= 1'b0;

            if (xfer && verdict.flag)
                rx_flag <= 1'b1;
            else if (wr_clr && cfg_wdata[0])
                rx_flag <= 1'b0;

            if (ovr_evt)
                ovr_flag <= 1'b1;
            else if (wr_clr && cfg_wdata[1])
                ovr_flag <= 1'b0;
        end
    end

    // R9: overrun flag is sticky until software clears it
    AST_OVR_STICKY: assert property (@(posedge clk) disable iff (rst)
        (ovr_flag && !wr_clr) |=> ovr_flag); // R9

    // R10: a clear write with bit 0 set and no new event drops the flag
    AST_FLAG_CLEAR: assert property (@(posedge clk) disable iff (rst)
        (wr_clr && cfg_wdata[0] && !xfer) |=> !rx_flag); // R10

endmodule

// File: rtl/uart_rxq.sv
module uart_rxq
    import uart_rxq_pkg::*;
#(
    parameter int AW = 16,
    parameter int SW = 8,
    parameter int DW = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rx_valid,
    input  logic [DW-1:0]     rx_byte,
    input  logic              ext_halt_n,
    input  logic              cfg_we,
    input  logic [2:0]        cfg_sel,
    input  logic [AW-1:0]     cfg_wdata,
    output logic              mem_we,
    output logic [AW-1:0]     mem_addr,
    output logic [DW-1:0]     mem_wdata,
    output logic [AW-1:0]     cur_addr,
    output logic [SW-1:0]     cur_size,
    output logic [CTRL_W-1:0] cur_ctrl,
    output logic              rx_flag,
    output logic              ovr_flag
);

    localparam logic [SW-1:0] SIZE_ONE = SW'(1);

    initial begin
        assert (AW >= SW && AW >= DW && AW >= CTRL_W)
            else $error("config data must hold every register field");
    end

    rxq_ctrl_t     ctrl;
    rxq_verdict_t  verdict;
    logic          xfer;
    logic          pend_v;
    logic          ovr_evt;
    logic [DW-1:0] pend_data;
    logic [DW-1:0] match_chr;
    logic [AW-1:0] addr_start;
    logic [SW-1:0] size_init;

    rxq_pend #(.DW(DW)) u_pend (
        .clk       (clk),
        .rst       (rst),
        .rx_valid  (rx_valid),
        .rx_byte   (rx_byte),
        .take      (xfer),
        .pend_v    (pend_v),
        .pend_data (pend_data),
        .ovr_evt   (ovr_evt)
    );

    rxq_engine #(.AW(AW), .SW(SW), .DW(DW)) u_engine (
        .ctrl       (ctrl),
        .ext_halt_n (ext_halt_n),
        .pend_v     (pend_v),
        .pend_data  (pend_data),
        .match_chr  (match_chr),
        .addr       (cur_addr),
        .size       (cur_size),
        .xfer       (xfer),
        .verdict    (verdict),
        .mem_we     (mem_we),
        .mem_addr   (mem_addr),
        .mem_wdata  (mem_wdata)
    );

    rxq_regs #(.AW(AW), .SW(SW), .DW(DW)) u_regs (
        .clk        (clk),
        .rst        (rst),
        .cfg_we     (cfg_we),
        .cfg_sel    (cfg_sel),
        .cfg_wdata  (cfg_wdata),
        .xfer       (xfer),
        .verdict    (verdict),
        .ovr_evt    (ovr_evt),
        .ctrl       (ctrl),
        .addr       (cur_addr),
        .size       (cur_size),
        .addr_start (addr_start),
        .size_init  (size_init),
        .match_chr  (match_chr),
        .rx_flag    (rx_flag),
        .ovr_flag   (ovr_flag)
    );

    assign cur_ctrl = ctrl;

    logic cfg_quiet;
    logic hit_now;
    assign cfg_quiet = !cfg_we;
    assign hit_now   = ctrl.match_en && (mem_wdata == match_chr);

    // R2: an ordinary write steps the address by one
    AST_ADDR_STEP: assert property (@(posedge clk) disable iff (rst)
        (mem_we && cfg_quiet && !(ctrl.circ && cur_size == SIZE_ONE))
        |=> cur_addr == AW'($past(cur_addr) + 1'b1)); // R2

    // R3: a terminator match halts the queue and raises the flag
    AST_MATCH_STOPS: assert property (@(posedge clk) disable iff (rst)
        (mem_we && hit_now && cfg_quiet) |=> (!ctrl.run && rx_flag)); // R3

    // R4: linear buffer stops at its end
    AST_LINEAR_STOP: assert property (@(posedge clk) disable iff (rst)
        (mem_we && cur_size == SIZE_ONE && !ctrl.cont && !ctrl.circ && cfg_quiet)
        |=> (!ctrl.run && rx_flag)); // R4

    // R5: continue policy keeps running past the end
    AST_CONT_RUNS: assert property (@(posedge clk) disable iff (rst)
        (mem_we && ctrl.cont && !ctrl.circ && !hit_now && cfg_quiet) |=> ctrl.run); // R5

    // R6: circular policy reloads the count at its end
    AST_CIRC_RELOAD: assert property (@(posedge clk) disable iff (rst)
        (mem_we && ctrl.circ && cur_size == SIZE_ONE && !hit_now && cfg_quiet)
        |=> (cur_size == size_init && cur_addr == addr_start && rx_flag)); // R6

    // R7, R8: no write while either halt is active
    AST_HALT_BLOCKS: assert property (@(posedge clk) disable iff (rst)
        (ctrl.halt || !ext_halt_n) |-> !mem_we); // R7 R8

    // R12: disabled queue never writes
    AST_QEN_BLOCKS: assert property (@(posedge clk) disable iff (rst)
        !ctrl.q_en |-> !mem_we); // R12

endmodule

// File: tb/sim_uart_rxq.sv
module sim_uart_rxq;

    localparam int AW = 8;
    localparam int SW = 4;
    localparam int DW = 8;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          rx_valid = 1'b0;
    logic [DW-1:0] rx_byte = '0;
    logic          ext_halt_n = 1'b1;
    logic          cfg_we = 1'b0;
    logic [2:0]    cfg_sel = '0;
    logic [AW-1:0] cfg_wdata = '0;
    logic          mem_we;
    logic [AW-1:0] mem_addr;
    logic [DW-1:0] mem_wdata;
    logic [AW-1:0] cur_addr;
    logic [SW-1:0] cur_size;
    logic [5:0]    cur_ctrl;
    logic          rx_flag;
    logic          ovr_flag;

    int n_vec = 0;
    int n_bad = 0;

    logic          saw_we;
    logic [AW-1:0] saw_addr;
    logic [DW-1:0] saw_data;

    // control bits: 0 q_en, 1 match_en, 2 cont, 3 circ, 4 run, 5 halt
    localparam logic [7:0] C_QEN = 8'h01, C_MEN = 8'h02, C_CONT = 8'h04,
                           C_CIRC = 8'h08, C_RUN = 8'h10, C_HLT = 8'h20;

    // {byte, expected write address, expected count after, {irq, run}}
    localparam logic [31:0] VEC [3] = '{
        {8'h41, 8'h20, 8'h05, 8'h01},
        {8'h42, 8'h21, 8'h04, 8'h01},
        {8'h0D, 8'h22, 8'h03, 8'h02}
    };

    uart_rxq #(.AW(AW), .SW(SW), .DW(DW)) u0 (
        .clk(clk), .rst(rst), .rx_valid(rx_valid), .rx_byte(rx_byte),
        .ext_halt_n(ext_halt_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .cur_addr(cur_addr), .cur_size(cur_size),
        .cur_ctrl(cur_ctrl), .rx_flag(rx_flag), .ovr_flag(ovr_flag)
    );

    always #2 clk = ~clk;

    initial begin
        #800000;
        n_vec++;
        n_bad++;
        $display("FAIL watchdog: act=hung exp=done");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        ext_halt_n = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic cfg(input logic [2:0] sel, input logic [7:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    // drives one byte, records the memory port in the following cycle
    task automatic send(input logic [7:0] b);
        @(negedge clk);
        rx_valid = 1'b1; rx_byte = b;
        @(negedge clk);
        rx_valid = 1'b0;
        saw_we = mem_we; saw_addr = mem_addr; saw_data = mem_wdata;
        @(negedge clk);
    endtask

    initial begin
        do_reset();
        // R1 reset state
        chk("R1 addr", 32'(cur_addr), 0);
        chk("R1 size", 32'(cur_size), 0);
        chk("R1 ctrl", 32'(cur_ctrl), 0);
        chk("R1 flags", {30'd0, rx_flag, ovr_flag}, 0);
        chk("R1 mem_we", 32'(mem_we), 0);

        // table walk: R2 writes, R3 terminator
        cfg(3'd0, 8'd6);
        cfg(3'd1, 8'h20);
        cfg(3'd2, 8'h0D);
        cfg(3'd3, C_QEN | C_MEN | C_RUN);
        chk("R11 ctrl word", 32'(cur_ctrl), 32'(C_QEN | C_MEN | C_RUN));
        for (int i = 0; i < 3; i++) begin
            send(VEC[i][31:24]);
            chk("R2 we", 32'(saw_we), 1);
            chk("R2 addr", 32'(saw_addr), 32'(VEC[i][23:16]));
            chk("R2 data", 32'(saw_data), 32'(VEC[i][31:24]));
            chk("R2 size", 32'(cur_size), 32'(VEC[i][15:8]));
            chk("R3 flag", 32'(rx_flag), 32'(VEC[i][1]));
            chk("R3 run", 32'(cur_ctrl[4]), 32'(VEC[i][0]));
        end
        send(8'h55);
        chk("R3 no write after match", 32'(saw_we), 0);

        // R4 linear end
        do_reset();
        cfg(3'd0, 8'd2);
        cfg(3'd1, 8'h10);
        cfg(3'd3, C_QEN | C_RUN);
        send(8'hA0);
        send(8'hA1);
        chk("R4 addr", 32'(saw_addr), 32'h11);
        chk("R4 size", 32'(cur_size), 0);
        chk("R4 flag", 32'(rx_flag), 1);
        chk("R4 run", 32'(cur_ctrl[4]), 0);
        send(8'hA2);
        chk("R4 no write", 32'(saw_we), 0);

        // R5 continue
        do_reset();
        cfg(3'd0, 8'd2);
        cfg(3'd1, 8'h30);
        cfg(3'd3, C_QEN | C_CONT | C_RUN);
        send(8'hB0);
        send(8'hB1);
        chk("R5 flag", 32'(rx_flag), 1);
        chk("R5 run", 32'(cur_ctrl[4]), 1);
        send(8'hB2);
        chk("R5 we", 32'(saw_we), 1);
        chk("R5 addr", 32'(saw_addr), 32'h32);
        chk("R5 size wrap", 32'(cur_size), 32'hF);

        // R6 circular
        do_reset();
        cfg(3'd0, 8'd3);
        cfg(3'd1, 8'h40);
        cfg(3'd3, C_QEN | C_CIRC | C_RUN);
        send(8'hC0);
        send(8'hC1);
        send(8'hC2);
        chk("R6 addr reload", 32'(cur_addr), 32'h40);
        chk("R6 size reload", 32'(cur_size), 3);
        chk("R6 flag", 32'(rx_flag), 1);
        chk("R6 run", 32'(cur_ctrl[4]), 1);
        send(8'hC3);
        chk("R6 wrapped write", 32'(saw_addr), 32'h40);

        // R7 halt bit, R9 overrun, R10 clear
        do_reset();
        cfg(3'd0, 8'd8);
        cfg(3'd1, 8'h50);
        cfg(3'd3, C_QEN | C_RUN | C_HLT);
        send(8'hD0);
        chk("R7 no write halted", 32'(saw_we), 0);
        send(8'hD1);
        chk("R9 overrun", 32'(ovr_flag), 1);
        chk("R7 still none", 32'(mem_we), 0);
        cfg(3'd3, C_QEN | C_RUN);
        chk("R7 release we", 32'(mem_we), 1);
        chk("R9 first kept", 32'(mem_wdata), 32'hD0);
        @(negedge clk);
        chk("R9 sticky", 32'(ovr_flag), 1);
        cfg(3'd4, 8'h00);
        chk("R10 zero keeps", 32'(ovr_flag), 1);
        cfg(3'd4, 8'h02);
        chk("R10 clear", 32'(ovr_flag), 0);

        // R8 external halt
        do_reset();
        cfg(3'd0, 8'd8);
        cfg(3'd1, 8'h60);
        cfg(3'd3, C_QEN | C_RUN);
        @(negedge clk);
        ext_halt_n = 1'b0;
        send(8'hE0);
        chk("R8 no write", 32'(saw_we), 0);
        ext_halt_n = 1'b1;
        #1;
        chk("R8 release we", 32'(mem_we), 1);
        chk("R8 addr", 32'(mem_addr), 32'h60);

        // R12 queue disabled, R10 receive flag clear
        do_reset();
        cfg(3'd0, 8'd1);
        cfg(3'd3, C_RUN);
        send(8'hF0);
        chk("R12 no write", 32'(saw_we), 0);
        cfg(3'd3, C_QEN | C_RUN);
        @(negedge clk);
        chk("R12 flag after enable", 32'(rx_flag), 1);
        cfg(3'd4, 8'h01);
        chk("R10 flag cleared", 32'(rx_flag), 0);

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule